// File: doc/BRIEF.md
# VBI Capture Window Controller

This block follows the vertical timing of a video input running with separate horizontal and vertical sync inputs. It keeps two line counts. One restarts when VSYNC rises and the other restarts when VSYNC falls, and both advance on each rising edge of HSYNC. A vertical-blanking data window flag is raised once the rising-edge count has reached a programmed start line. The flag drops once the falling-edge count has reached a programmed end line. Because the two limits are measured from opposite edges of VSYNC, a pair of values whose ranges do not overlap gives a window that never opens.

The block also holds the destination base addresses for blanking data in odd and even fields. Each address is double buffered. A write from software lands in a pending copy, and a status flag rises to show that an update is waiting. The first-data strobe from the capture path marks the boundary of the next field. At that strobe, both pending copies move into the active registers in the same cycle and the flag clears. The field-parity input is sampled when VSYNC rises, and it selects which active address the block presents for the current field.

Top module: `vbi_window_ctrl`

## Requirements
- R1: After reset, `vbi_active`, `update_pending`, `odd_base`, `even_base` and `cur_base` are all zero, and the window register holds start 0 and end 0.
- R2: `wr_addr` 2 writes the window register, with the start line in `wr_data[11:0]` and the end line in `wr_data[27:16]`. The window opens once the number of HSYNC rising edges since the last VSYNC rising edge is at least the start line.
- R3: The window closes once the number of HSYNC rising edges since the last VSYNC falling edge is at least the end line. Closing takes priority over opening. Each count saturates at 4095.
- R4: When the start and end limits do not overlap in a field, `vbi_active` stays low for that whole field. With end 0, it is low at all times.
- R5: A write to `wr_addr` 0 (odd base) or 1 (even base) goes to the pending copy only, and `odd_base`/`even_base` keep their previous values.
- R6: A base-address write sets `update_pending` on the following clock. A write to the window register does not change `update_pending`.
- R7: When `first_data` is high, both pending addresses are copied to `odd_base` and `even_base` in the same cycle, and `update_pending` clears.
- R8: Bits [4:0] of every stored base address are forced to zero.
- R9: If a base write arrives in the same cycle as `first_data`, the active registers take the pending values held before that write. The new value stays pending and `update_pending` stays 1.
- R10: `cur_base` shows `odd_base` when `field_odd` was 1 at the last VSYNC rising edge, and `even_base` otherwise.
- R11: Every output reflects a sampled input change after exactly one rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are synchronous to it |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 odd base, 1 even base, 2 window, 3 unused |
| wr_data | input | 32 | Write data |
| hsync | input | 1 | Horizontal sync; a rising edge advances the line counts |
| vsync | input | 1 | Vertical sync; the rising edge restarts the start count and the falling edge restarts the end count |
| field_odd | input | 1 | Field parity, sampled when VSYNC rises |
| first_data | input | 1 | Strobe marking the first captured data of a field |
| vbi_active | output | 1 | Blanking-data window flag |
| odd_base | output | 32 | Active odd-field base address |
| even_base | output | 32 | Active even-field base address |
| cur_base | output | 32 | Active address selected by the sampled parity |
| update_pending | output | 1 | A pending base update is waiting for `first_data` |

## Verification
Every result is due one rising edge after the input that causes it is sampled. A sync edge moves the counts and `vbi_active` at that edge. A write or `first_data` updates the registers at that edge. The bench drives inputs on the falling clock edge and compares on the next falling edge, which lies half a period after the responsible rising edge. The window sweep covers every start and end pair from 0 to 5 across a field and compares against counts that the bench keeps itself. The address checks are made directly before and after each strobe, so a value that changed early or late shows up as a miscompare.

// File: rtl/vbi_pkg.sv
package vbi_pkg;
   typedef enum logic [1:0] {
      REG_ODD_BASE  = 2'd0,
      REG_EVEN_BASE = 2'd1,
      REG_WINDOW    = 2'd2,
      REG_SPARE     = 2'd3
   } vbi_reg_e;

   localparam int unsigned WIN_END_LSB = 16;
endpackage

// File: rtl/vbi_edge_det.sv
module vbi_edge_det #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] sig,
   output logic [N-1:0] rise,
   output logic [N-1:0] fall
);
   logic [N-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= sig;
   end

   assign rise = sig & ~prev_q;
   assign fall = ~sig & prev_q;
endmodule

// File: rtl/vbi_line_track.sv
module vbi_line_track #(
   parameter int unsigned LINE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hs_rise,
   input  logic              vs_rise,
   input  logic              vs_fall,
   input  logic [LINE_W-1:0] win_start,
   input  logic [LINE_W-1:0] win_end,
   output logic              vbi_active
);
   localparam logic [LINE_W-1:0] CNT_MAX = {LINE_W{1'b1}};

   logic [LINE_W-1:0] cnt_q [2];
   logic [1:0]        restart;

   assign restart = {vs_fall, vs_rise};

   for (genvar g = 0; g < 2; g++) begin : g_cnt
      always_ff @(posedge clk) begin
         if (!rst_n)
            cnt_q[g] <= '0;
         else if (restart[g])
            cnt_q[g] <= '0;
         else if (hs_rise && cnt_q[g] != CNT_MAX)
            cnt_q[g] <= cnt_q[g] + 1'b1;
      end
   end

   assign vbi_active = (cnt_q[0] >= win_start) && (cnt_q[1] < win_end);
endmodule

// File: rtl/vbi_base_bank.sv
module vbi_base_bank #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned ALIGN_BITS = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_odd,
   input  logic              wr_even,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic              first_data,
   input  logic              vs_rise,
   input  logic              field_odd,
   output logic [ADDR_W-1:0] odd_base,
   output logic [ADDR_W-1:0] even_base,
   output logic [ADDR_W-1:0] cur_base,
   output logic              update_pending
);
   logic [ADDR_W-1:0] aligned;
   logic [ADDR_W-1:0] pend_odd_q, pend_even_q;
   logic              parity_q;

   if (ALIGN_BITS == 0) begin : g_noalign
      assign aligned = wr_data;
   end else begin : g_align
      assign aligned = {wr_data[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_odd_q     <= '0;
         pend_even_q    <= '0;
         odd_base       <= '0;
         even_base      <= '0;
         update_pending <= 1'b0;
         parity_q       <= 1'b0;
      end else begin
         if (first_data) begin
            odd_base  <= pend_odd_q;
            even_base <= pend_even_q;
         end
         if (wr_odd)  pend_odd_q  <= aligned;
         if (wr_even) pend_even_q <= aligned;
         if (wr_odd || wr_even)  update_pending <= 1'b1;
         else if (first_data)    update_pending <= 1'b0;
         if (vs_rise) parity_q <= field_odd;
      end
   end

   assign cur_base = parity_q ? odd_base : even_base;
endmodule

// File: rtl/vbi_window_ctrl.sv
module vbi_window_ctrl
   import vbi_pkg::*;
#(
   parameter int unsigned LINE_W     = 12,
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned ALIGN_BITS = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic              hsync,
   input  logic              vsync,
   input  logic              field_odd,
   input  logic              first_data,
   output logic              vbi_active,
   output logic [ADDR_W-1:0] odd_base,
   output logic [ADDR_W-1:0] even_base,
   output logic [ADDR_W-1:0] cur_base,
   output logic              update_pending
);
   localparam int unsigned END_MSB = WIN_END_LSB + LINE_W - 1;

   if (LINE_W < 1 || LINE_W > WIN_END_LSB) begin : g_bad_line
      $error("LINE_W must lie in 1..16");
   end
   if (ADDR_W < END_MSB + 1) begin : g_bad_addr
      $error("ADDR_W too narrow for the window field");
   end
   if (ALIGN_BITS >= ADDR_W) begin : g_bad_align
      $error("ALIGN_BITS must be below ADDR_W");
   end

   logic [1:0]        rise, fall;
   logic [LINE_W-1:0] start_q, end_q;
   logic              wr_win, wr_odd, wr_even;

   assign wr_win  = wr_en && (wr_addr == REG_WINDOW);
   assign wr_odd  = wr_en && (wr_addr == REG_ODD_BASE);
   assign wr_even = wr_en && (wr_addr == REG_EVEN_BASE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= '0;
         end_q   <= '0;
      end else if (wr_win) begin
         start_q <= wr_data[LINE_W-1:0];
         end_q   <= wr_data[END_MSB:WIN_END_LSB];
      end
   end

   vbi_edge_det #(.N(2)) u_edges (
      .clk  (clk),
      .rst_n(rst_n),
      .sig  ({vsync, hsync}),
      .rise (rise),
      .fall (fall)
   );

   vbi_line_track #(.LINE_W(LINE_W)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .hs_rise   (rise[0]),
      .vs_rise   (rise[1]),
      .vs_fall   (fall[1]),
      .win_start (start_q),
      .win_end   (end_q),
      .vbi_active(vbi_active)
   );

   vbi_base_bank #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_bank (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_odd        (wr_odd),
      .wr_even       (wr_even),
      .wr_data       (wr_data),
      .first_data    (first_data),
      .vs_rise       (rise[1]),
      .field_odd     (field_odd),
      .odd_base      (odd_base),
      .even_base     (even_base),
      .cur_base      (cur_base),
      .update_pending(update_pending)
   );
endmodule

// File: rtl/vbi_window_ctrl_chk.sv
module vbi_window_ctrl_chk #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        wr_addr,
   input logic              hsync,
   input logic              vsync,
   input logic              first_data,
   input logic              vbi_active,
   input logic [ADDR_W-1:0] odd_base,
   input logic [ADDR_W-1:0] even_base,
   input logic              update_pending
);
   logic hs_p, vs_p, base_wr, quiet;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hs_p <= 1'b0;
         vs_p <= 1'b0;
      end else begin
         hs_p <= hsync;
         vs_p <= vsync;
      end
   end

   assign base_wr = wr_en && (wr_addr == 2'd0 || wr_addr == 2'd1);
   assign quiet   = (hsync == hs_p) && (vsync == vs_p) && !(wr_en && wr_addr == 2'd2);

   AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
      base_wr |=> update_pending); // R6
   AST_PEND_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (first_data && !base_wr) |=> !update_pending); // R7
   AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !first_data |=> ($stable(odd_base) && $stable(even_base))); // R5
   AST_NOPEND_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (first_data && !update_pending) |=> $stable(odd_base)); // R7
   AST_WIN_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      quiet |=> $stable(vbi_active)); // R11
endmodule

bind vbi_window_ctrl vbi_window_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/vbi_window_ctrl_bench.sv
module vbi_window_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        hsync = 1'b0, vsync = 1'b0, field_odd = 1'b0, first_data = 1'b0;
   logic        vbi_active, update_pending;
   logic [31:0] odd_base, even_base, cur_base;

   int n_chk = 0, n_bad = 0;
   int lead = 0, trail = 0, ws = 0, we = 0;
   bit done = 0;

   always #10 clk = ~clk;

   vbi_window_ctrl u_vbi_window_ctrl (.*);

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [1:0] a, input logic [31:0] d, input bit fd);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d; first_data = fd;
      @(negedge clk);
      wr_en = 1'b0; first_data = 1'b0;
   endtask

   function automatic bit exp_win();
      return (lead >= ws) && (trail < we);
   endfunction

   task automatic win_chk();
      chk(vbi_active == exp_win(), (we == 0) ? "R4" : "R2 R3 R11",
          {31'd0, vbi_active}, {31'd0, exp_win()});
   endtask

   task automatic hs_line();
      @(negedge clk) hsync = 1'b1;
      @(negedge clk);
      lead++; trail++;
      win_chk();
      hsync = 1'b0;
   endtask

   task automatic vs_set(input bit v);
      @(negedge clk) vsync = v;
      @(negedge clk);
      if (v) lead = 0; else trail = 0;
      win_chk();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(vbi_active == 1'b0, "R1", {31'd0, vbi_active}, 0);
      chk(update_pending == 1'b0, "R1", {31'd0, update_pending}, 0);
      chk(odd_base == 0 && even_base == 0 && cur_base == 0, "R1", odd_base | even_base | cur_base, 0);

      // window sweep over start/end 0..5
      for (int s = 0; s < 6; s++) begin
         for (int e = 0; e < 6; e++) begin
            reg_wr(2'd2, (32'(e) << 16) | 32'(s), 1'b0);
            ws = s; we = e;
            win_chk();
            chk(update_pending == 1'b0, "R6", {31'd0, update_pending}, 0);
            vs_set(1'b1);
            for (int l = 0; l < 2; l++) hs_line();
            vs_set(1'b0);
            for (int l = 0; l < 10; l++) hs_line();
         end
      end

      // R5 R6 R8: writes held pending
      reg_wr(2'd0, 32'h1234_567F, 1'b0);
      chk(update_pending == 1'b1, "R6", {31'd0, update_pending}, 1);
      chk(odd_base == 0, "R5", odd_base, 0);
      reg_wr(2'd1, 32'hABCD_EF1F, 1'b0);
      chk(even_base == 0, "R5", even_base, 0);
      // R7 transfer
      @(negedge clk) first_data = 1'b1;
      @(negedge clk) first_data = 1'b0;
      chk(odd_base == 32'h1234_5660, "R7 R8", odd_base, 32'h1234_5660);
      chk(even_base == 32'hABCD_EF00, "R7 R8", even_base, 32'hABCD_EF00);
      chk(update_pending == 1'b0, "R7", {31'd0, update_pending}, 0);
      // R10 parity select
      chk(cur_base == 32'hABCD_EF00, "R10", cur_base, 32'hABCD_EF00);
      field_odd = 1'b1;
      vs_set(1'b1);
      chk(cur_base == 32'h1234_5660, "R10", cur_base, 32'h1234_5660);
      field_odd = 1'b0;
      vs_set(1'b0);
      chk(cur_base == 32'h1234_5660, "R10", cur_base, 32'h1234_5660);
      // R9 collision
      reg_wr(2'd0, 32'h0000_1000, 1'b0);
      reg_wr(2'd0, 32'h0000_2000, 1'b1);
      chk(odd_base == 32'h0000_1000, "R9", odd_base, 32'h0000_1000);
      chk(update_pending == 1'b1, "R9", {31'd0, update_pending}, 1);
      @(negedge clk) first_data = 1'b1;
      @(negedge clk) first_data = 1'b0;
      chk(odd_base == 32'h0000_2000, "R9", odd_base, 32'h0000_2000);
      chk(even_base == 32'hABCD_EF00, "R7", even_base, 32'hABCD_EF00);
      chk(update_pending == 1'b0, "R9", {31'd0, update_pending}, 0);
      done = 1;
   end

   initial begin
      for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule